// File: doc/BRIEF.md
# Microsecond Down-Counting Timer Bank

This block is a small bank of independent down-counting timers that software sets up through a simple word-wide register port. Every channel counts a shared microsecond tick strobe. It runs either once or repeatedly, and raises its own active-high interrupt level when its count runs out. That level stays high until software clears it.

Each channel has two words, and consecutive channels are eight bytes apart. The word at offset 0 is the control word. It holds an enable flag in bit 31, a repeat flag in bit 30 and the start value in the low 29 bits. A start value of n expires on the (n+1)th counted tick. The word at offset 4 is the status word. Reading it returns the remaining count and the pending flag. Writing it with bit 30 set clears the pending flag. Writing the control word always restarts the channel from the new value, and a control word of zero stops the channel.

Top module: `timer_bank`

## Requirements
- R1: After reset every channel is disabled with a zero count, a zero start value and no pending interrupt. Every register reads 0 and all `irq` bits are low.
- R2: A write to byte address 8*c+0 sets the control word of channel c. Bit 31 is the enable flag, bit 30 is the repeat flag and bits [28:0] are the start value. Reading the same address returns bit 31 = enable, bit 30 = repeat, bits [28:0] = start value, and bit 29 = 0. Address bits [1:0] are ignored.
- R3: With start value n loaded and enabled, the pending flag and `irq[c]` go high in the cycle after the (n+1)th clock edge at which `usTick` was high. After n such edges they are still low.
- R4: The count drops by one only on a clock edge where `usTick` is high and the channel is enabled. Otherwise the count holds, including when the channel is disabled.
- R5: In one-shot mode (bit 30 = 0) the enable flag clears on expiry and the count stays at 0. The channel then stops counting.
- R6: In repeat mode (bit 30 = 1) the count reloads the start value on each expiry, so expiry recurs every n+1 ticks.
- R7: The pending flag, and the level on `irq[c]`, stays high until a write to address 8*c+4 with bit 30 = 1. A write to that address with bit 30 = 0 leaves it unchanged.
- R8: When an expiry and a clear write fall on the same clock edge, the pending flag stays set.
- R9: A control write while the channel runs restarts the count from the new value at once. A control word of 0 disables the channel and zeroes its count.
- R10: Reading address 8*c+4 returns the remaining count in bits [28:0], the pending flag in bit 30, and 0 in all other bits.
- R11: Channels are independent. A write reaches only the addressed channel. Addresses at or beyond 8*NUM_CH are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | Microsecond tick strobe; counting happens only on cycles where it is high |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, available in the same cycle |
| irq | output | NUM_CH | Per-channel active-high interrupt level |

## Verification
A register write takes effect at the clock edge that samples it, so a read issued in the following half cycle already returns the new value. Reads themselves are combinational. The bench drives each write or tick at a falling edge and samples the ports one nanosecond after a later falling edge. A counted tick changes the count at the next rising edge. An expiry on the (n+1)th tick edge shows up on `irq` and in the status word straight after that edge. The table-driven runs therefore stop the tick after exactly the listed number of edges and compare there. The directed cases for restart, stop and clear-versus-expiry collisions check the outputs after each single edge.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  // Bit positions inside the 32-bit register words.
  localparam int CtlEnableBit   = 31;
  localparam int CtlRepeatBit   = 30;
  localparam int StsPendingBit  = 30;
  localparam int ClrPendingBit  = 30;
  localparam int ChanStrideLog2 = 3;   // 8-byte spacing between channels

  // Strobes from the register decode to one channel datapath.
  typedef struct packed {
    logic loadCtl;    // control word written this cycle
    logic clearPend;  // status word written with the clear bit set
  } chanStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              chEnable [NUM_CH],
  input  logic              chRepeat [NUM_CH],
  input  logic [CNT_W-1:0]  chReload [NUM_CH],
  input  logic [CNT_W-1:0]  chCount  [NUM_CH],
  input  logic              chPend   [NUM_CH],
  output chanStrobe_t       strobe   [NUM_CH],
  output logic              ldEnable,
  output logic              ldRepeat,
  output logic [CNT_W-1:0]  ldValue,
  output logic [31:0]       rdData
);
  localparam int SEL_W = ADDR_W - ChanStrideLog2;

  logic [SEL_W-1:0]  chanSel;
  logic              isStatus;
  logic [NUM_CH-1:0] match;
  logic [NUM_CH-1:0] loadVec;
  logic [NUM_CH-1:0] clearVec;

  assign chanSel  = addr[ADDR_W-1:ChanStrideLog2];
  assign isStatus = addr[2];

  // Control-word fields are broadcast; only the strobed channel takes them.
  assign ldEnable = wrData[CtlEnableBit];
  assign ldRepeat = wrData[CtlRepeatBit];
  assign ldValue  = wrData[CNT_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_decode
    localparam logic [SEL_W-1:0] MySel = SEL_W'(c);
    assign match[c]            = (chanSel == MySel);
    assign loadVec[c]          = wrEn && match[c] && !isStatus;
    assign clearVec[c]         = wrEn && match[c] && isStatus && wrData[ClrPendingBit];
    assign strobe[c].loadCtl   = loadVec[c];
    assign strobe[c].clearPend = clearVec[c];
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (match[c]) begin
        if (isStatus) begin
          rdData[CNT_W-1:0]    = chCount[c];
          rdData[StsPendingBit] = chPend[c];
        end else begin
          rdData[CNT_W-1:0]   = chReload[c];
          rdData[CtlEnableBit] = chEnable[c];
          rdData[CtlRepeatBit] = chRepeat[c];
        end
      end
    end
  end

  // R11: a write never reaches more than one channel
  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadVec | clearVec));

  // R11: an address outside the bank reads as zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (match == '0) |-> (rdData == 32'd0));
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_bank_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  chanStrobe_t      strobe,
  input  logic             ldEnable,
  input  logic             ldRepeat,
  input  logic [CNT_W-1:0] ldValue,
  output logic             enable,
  output logic             repeatMode,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             pending
);
  logic tickNow;
  logic expire;

  assign tickNow = enable && usTick && !strobe.loadCtl;
  assign expire  = tickNow && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable     <= 1'b0;
      repeatMode <= 1'b0;
      reload     <= '0;
      count      <= '0;
    end else if (strobe.loadCtl) begin
      enable     <= ldEnable;
      repeatMode <= ldRepeat;
      reload     <= ldValue;
      count      <= ldValue;
    end else if (tickNow) begin
      if (count == '0) begin
        if (repeatMode) count <= reload;
        else            enable <= 1'b0;
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end

  // Expiry outranks a clear arriving on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN)                 pending <= 1'b0;
    else if (expire)           pending <= 1'b1;
    else if (strobe.clearPend) pending <= 1'b0;
  end

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!usTick && !strobe.loadCtl) |=> $stable(count));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && usTick && !strobe.loadCtl && count != '0)
      |=> (count == $past(count) - CNT_W'(1)));

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !repeatMode && usTick && !strobe.loadCtl && count == '0)
      |=> (!enable && count == '0 && pending));

  assert_repeat_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && repeatMode && usTick && !strobe.loadCtl && count == '0)
      |=> (enable && count == $past(reload) && pending));

  assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strobe.clearPend) |=> pending);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCtl |=> (count == $past(ldValue) && enable == $past(ldEnable)));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] irq
);
  chanStrobe_t      strobe   [NUM_CH];
  logic             chEnable [NUM_CH];
  logic             chRepeat [NUM_CH];
  logic [CNT_W-1:0] chReload [NUM_CH];
  logic [CNT_W-1:0] chCount  [NUM_CH];
  logic             chPend   [NUM_CH];
  logic             ldEnable;
  logic             ldRepeat;
  logic [CNT_W-1:0] ldValue;

  timer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .chEnable (chEnable),
    .chRepeat (chRepeat),
    .chReload (chReload),
    .chCount  (chCount),
    .chPend   (chPend),
    .strobe   (strobe),
    .ldEnable (ldEnable),
    .ldRepeat (ldRepeat),
    .ldValue  (ldValue),
    .rdData   (rdData)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rstN       (rstN),
      .usTick     (usTick),
      .strobe     (strobe[c]),
      .ldEnable   (ldEnable),
      .ldRepeat   (ldRepeat),
      .ldValue    (ldValue),
      .enable     (chEnable[c]),
      .repeatMode (chRepeat[c]),
      .reload     (chReload[c]),
      .count      (chCount[c]),
      .pending    (chPend[c])
    );
    assign irq[c] = chPend[c];
  end
endmodule

// File: tb/timer_bank_test.sv
module timer_bank_test;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 29;

  logic              clk = 1'b0;
  logic              rstN;
  logic              usTick;
  logic              wrEn;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wrData;
  logic [31:0]       rdData;
  logic [NUM_CH-1:0] irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  timer_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Table-driven runs: channel, repeat flag, start value, ticks, expected irq, expected count.
  localparam int NV = 8;
  localparam int VCH  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int VREP [NV] = '{0, 0, 0, 0, 1, 1, 0, 1};
  localparam int VN   [NV] = '{5, 5, 5, 5, 3, 3, 0, 0};
  localparam int VTK  [NV] = '{3, 5, 6, 9, 4, 6, 1, 3};
  localparam int VIRQ [NV] = '{0, 0, 1, 1, 1, 1, 1, 1};
  localparam int VCNT [NV] = '{2, 0, 0, 0, 3, 1, 0, 0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic runTicks(input int k);
    usTick = 1'b1;
    for (int i = 0; i < k; i++) @(negedge clk);
    usTick = 1'b0;
    #1;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
    #1;
  endtask

  function automatic logic [ADDR_W-1:0] chAddr(input int ch, input int off);
    return ADDR_W'(ch * 8 + off);
  endfunction

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; usTick = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    for (int c = 0; c < NUM_CH; c++) begin
      readReg(chAddr(c, 0), rd); check("R1 ctrl", rd, 32'd0);
      readReg(chAddr(c, 4), rd); check("R1 status", rd, 32'd0);
    end
    @(negedge clk);

    // Table walk: R3 expiry on (n+1)th tick, R5 one-shot, R6 repeat, R10 status layout
    for (int v = 0; v < NV; v++) begin
      writeReg(chAddr(VCH[v], 4), 32'h4000_0000);
      writeReg(chAddr(VCH[v], 0), 32'h8000_0000 | (32'(VREP[v]) << 30) | 32'(VN[v]));
      runTicks(VTK[v]);
      check("R3 irq level", 32'(irq[VCH[v]]), 32'(VIRQ[v]));
      readReg(chAddr(VCH[v], 4), rd);
      check("R10 status word", rd, (32'(VIRQ[v]) << 30) | 32'(VCNT[v]));
      readReg(chAddr(VCH[v], 0), rd);
      check("R5 R6 enable after run", 32'(rd[31]),
            (VREP[v] == 1 || VTK[v] <= VN[v]) ? 32'd1 : 32'd0);
      @(negedge clk);
      writeReg(chAddr(VCH[v], 0), 32'd0);
    end
    for (int c = 0; c < NUM_CH; c++) writeReg(chAddr(c, 4), 32'h4000_0000);
    #1;
    check("R7 all cleared", 32'(irq), 32'd0);
    @(negedge clk);

    // R2: control readback, bit 29 not stored, byte offset ignored
    writeReg(chAddr(2, 0), 32'hFFFF_FFFF);
    readReg(chAddr(2, 0) | ADDR_W'(3), rd);
    check("R2 ctrl readback", rd, 32'hDFFF_FFFF);
    readReg(chAddr(2, 4), rd);
    check("R10 max count", rd, 32'h1FFF_FFFF);
    @(negedge clk);
    writeReg(chAddr(2, 0), 32'd0);

    // R4: gaps in the tick strobe hold the count
    writeReg(chAddr(1, 0), 32'h8000_0004);
    runTicks(2);
    idle(3);
    readReg(chAddr(1, 4), rd);
    check("R4 count with tick gaps", rd, 32'd2);
    @(negedge clk);
    runTicks(2);
    check("R3 not yet expired", 32'(irq[1]), 32'd0);
    @(negedge clk);
    runTicks(1);
    check("R3 expired", 32'(irq[1]), 32'd1);

    // R7: level held, zero clear bit has no effect, set clear bit clears
    idle(10);
    check("R7 level held", 32'(irq[1]), 32'd1);
    @(negedge clk);
    writeReg(chAddr(1, 4), 32'hBFFF_FFFF);
    #1;
    check("R7 write without clear bit", 32'(irq[1]), 32'd1);
    @(negedge clk);
    writeReg(chAddr(1, 4), 32'h4000_0000);
    #1;
    check("R7 clear", 32'(irq[1]), 32'd0);
    readReg(chAddr(1, 0), rd);
    check("R5 one-shot enable cleared", rd, 32'h0000_0004);
    @(negedge clk);

    // R8: clear colliding with expiry keeps pending set
    writeReg(chAddr(3, 0), 32'hC000_0000);
    runTicks(1);
    check("R8 setup expiry", 32'(irq[3]), 32'd1);
    @(negedge clk);
    writeReg(chAddr(3, 4), 32'h4000_0000);
    #1;
    check("R8 plain clear", 32'(irq[3]), 32'd0);
    @(negedge clk);
    usTick = 1'b1;
    writeReg(chAddr(3, 4), 32'h4000_0000);
    usTick = 1'b0;
    #1;
    check("R8 expiry beats clear", 32'(irq[3]), 32'd1);
    @(negedge clk);
    writeReg(chAddr(3, 0), 32'd0);
    writeReg(chAddr(3, 4), 32'h4000_0000);

    // R9: restart while running, then stop with zero
    writeReg(chAddr(2, 0), 32'h8000_000A);
    runTicks(3);
    readReg(chAddr(2, 4), rd);
    check("R9 before restart", rd, 32'd7);
    @(negedge clk);
    writeReg(chAddr(2, 0), 32'h8000_0002);
    readReg(chAddr(2, 4), rd);
    check("R9 restart value", rd, 32'd2);
    @(negedge clk);
    runTicks(2);
    check("R9 no early expiry", 32'(irq[2]), 32'd0);
    @(negedge clk);
    runTicks(1);
    check("R9 expiry after restart", 32'(irq[2]), 32'd1);
    @(negedge clk);
    writeReg(chAddr(2, 0), 32'h8000_0064);
    runTicks(5);
    writeReg(chAddr(2, 0), 32'd0);
    readReg(chAddr(2, 0), rd);
    check("R9 stop ctrl", rd, 32'd0);
    readReg(chAddr(2, 4), rd);
    check("R9 stop status", rd, 32'h4000_0000);
    @(negedge clk);
    writeReg(chAddr(2, 4), 32'h4000_0000);
    runTicks(5);
    check("R9 stopped no irq", 32'(irq[2]), 32'd0);
    readReg(chAddr(2, 4), rd);
    check("R9 stopped count", rd, 32'd0);
    @(negedge clk);

    // R11: independence and unmapped addresses; R4 disabled channel holds
    writeReg(chAddr(1, 0), 32'hC000_0064);
    writeReg(chAddr(0, 0), 32'h0000_0007);
    runTicks(10);
    readReg(chAddr(0, 4), rd);
    check("R4 disabled holds", rd, 32'd7);
    readReg(chAddr(1, 4), rd);
    check("R11 neighbour counted", rd, 32'd90);
    @(negedge clk);
    writeReg(ADDR_W'(8'h20), 32'hFFFF_FFFF);
    writeReg(ADDR_W'(8'h24), 32'hFFFF_FFFF);
    readReg(ADDR_W'(8'h20), rd);
    check("R11 unmapped reads zero", rd, 32'd0);
    readReg(chAddr(0, 0), rd);
    check("R11 ch0 untouched", rd, 32'h0000_0007);
    readReg(chAddr(3, 0), rd);
    check("R11 ch3 untouched", rd, 32'd0);
    check("R11 irqs untouched", 32'(irq), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule